// File: doc/BRIEF.md
# Serial Audio Slot Transmitter

This block sends one audio word per time slot on a single serial data line. Software places a word in a 24-bit holding register. At the first bit-clock tick of a frame-sync-qualified slot, that word moves into a shift register without further action. It is then clocked out one bit per tick. The bit clock arrives as a one-cycle enable strobe in the system clock domain. Frame sync is a level input that qualifies every tick.

The slot can be 8, 12, 16, 20, 24 or 32 bits long, and the bits can go out most significant first or least significant first. The valid data is read from the upper part of a field of the holding register:
- In the wide mode the field is all 24 bits.
- In the narrow mode it is the low 16 bits, and the top byte is a don't-care.

Bits of a long slot that lie beyond the valid data go out as zeros. An empty flag and a maskable interrupt tell software when it may write the next word. An underrun flag marks a slot that started with nothing to send.

Top module: `slot_tx`

## Requirements
- R1: After reset, `serOut` is 0, `txEmpty` is 1 and `underrun` is 0. `irq` is 0 while `irqEn` is 0.
- R2: `serOut` changes only in the cycle after a cycle with `bitClkEn` high.
- R3: A tick with `frameSync` low drives `serOut` to 0 and does not advance the slot. The slot resumes at the next tick with `frameSync` high.
- R4: `slotLen` codes 0,1,2,3,4,5 select slot lengths of 8,12,16,20,24,32 bits, and codes 6 and 7 select 32. A slot ends after that many frame-sync-qualified ticks, and the next qualified tick starts a new slot. `slotLen`, `lsbFirst` and `align16` are sampled at the slot start.
- R5: With `lsbFirst`=0, the valid data bits are sent most significant first.
- R6: With `lsbFirst`=1, the valid data bits are sent least significant first.
- R7: With `align16`=0, the valid data is `wrData[23:24-W]` with W = min(slot length, 24). The lower bits are ignored.
- R8: With `align16`=1, bits [23:16] are ignored. The valid data is `wrData[15:16-W]` with W = min(slot length, 16).
- R9: The slot bits after the W data bits are sent as zeros in both bit orders.
- R10: The transfer into the shifter happens at the first qualified tick of a slot, and `txEmpty` is 1 from the next cycle. A write makes `txEmpty` 0 from the next cycle. A write in the transfer cycle keeps the new word.
- R11: A slot that starts while `txEmpty` is 1 sends all zeros. `underrun` is then 1 from the next cycle until a slot starts with a word present.
- R12: `irq` equals `txEmpty` AND `irqEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bitClkEn | input | 1 | One-cycle strobe per serial bit |
| frameSync | input | 1 | Level that qualifies bit ticks |
| wrEn | input | 1 | Holding register write strobe |
| wrData | input | 24 | Word written to the holding register |
| slotLen | input | 3 | Slot length code |
| lsbFirst | input | 1 | 1: least significant bit first |
| align16 | input | 1 | 1: take data from the low 16-bit field |
| irqEn | input | 1 | Interrupt enable |
| serOut | output | 1 | Serial data line |
| txEmpty | output | 1 | Holding register is empty |
| irq | output | 1 | Empty interrupt request |
| underrun | output | 1 | Last slot started with no data |

## Verification
The assertions assume the following about the inputs:
- `bitClkEn`, `frameSync`, `wrEn` and the configuration inputs are synchronous to `clk`.
- A tick is a single-cycle pulse.
- Nothing else is assumed about how often ticks, writes or frame-sync changes occur.

The stimulus raises `bitClkEn` for exactly one cycle with zero to two idle cycles between ticks. It changes the configuration only between slots. It places writes both before and in the middle of slots, and it drops frame sync inside a slot, so the pause and overlap cases are covered.

// File: rtl/slot_tx_pkg.sv
package slot_tx_pkg;

  // strobes issued by the control half to the datapath half
  typedef struct packed {
    logic loadSlot;   // first qualified tick of a slot
    logic shiftBit;   // later qualified tick inside a slot
    logic quietBit;   // tick while frame sync is low
    logic fillZero;   // nothing waiting at load time
  } txStrobes_t;

  function automatic int slotBits(input logic [2:0] code);
    case (code)
      3'd0:    return 8;
      3'd1:    return 12;
      3'd2:    return 16;
      3'd3:    return 20;
      3'd4:    return 24;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/slot_tx_ctl.sv
module slot_tx_ctl
  import slot_tx_pkg::*;
#(
  parameter int MAX_SLOT = 32,
  localparam int CNT_W = $clog2(MAX_SLOT + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bitClkEn,
  input  logic       frameSync,
  input  logic       wrEn,
  input  logic [2:0] slotLen,
  output txStrobes_t strb,
  output logic       txEmpty,
  output logic       underrun
);

  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] curLen;
  logic             holdFull;
  logic             slotIdle;

  assign slotIdle = (bitCnt == '0);

  always_comb begin
    strb.loadSlot = bitClkEn & frameSync & slotIdle;
    strb.shiftBit = bitClkEn & frameSync & ~slotIdle;
    strb.quietBit = bitClkEn & ~frameSync;
    strb.fillZero = ~holdFull;
  end

  // slot position counter; holds while frame sync is low
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bitCnt <= '0;
      curLen <= '0;
    end else if (strb.loadSlot) begin
      curLen <= CNT_W'(slotBits(slotLen));
      bitCnt <= CNT_W'(1);
    end else if (strb.shiftBit) begin
      if (bitCnt == curLen - CNT_W'(1)) bitCnt <= '0;
      else                              bitCnt <= bitCnt + CNT_W'(1);
    end
  end

  // holding register occupancy and underrun marker
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holdFull <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (wrEn)               holdFull <= 1'b1;
      else if (strb.loadSlot) holdFull <= 1'b0;
      if (strb.loadSlot)      underrun <= ~holdFull;
    end
  end

  assign txEmpty = ~holdFull;

endmodule

// File: rtl/slot_tx_dp.sv
module slot_tx_dp
  import slot_tx_pkg::*;
#(
  parameter int HOLD_W   = 24,
  parameter int NARROW_W = 16,
  parameter int MAX_SLOT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [HOLD_W-1:0] wrData,
  input  txStrobes_t        strb,
  input  logic [2:0]        slotLen,
  input  logic              lsbFirst,
  input  logic              align16,
  output logic              serOut
);

  logic [HOLD_W-1:0]   holdReg;
  logic [HOLD_W-1:0]   fieldVal;
  logic [HOLD_W-1:0]   rightData;
  logic [MAX_SLOT-1:0] wideData;
  logic [MAX_SLOT-1:0] msbSeq;
  logic [MAX_SLOT-1:0] lsbSeq;
  logic [MAX_SLOT-1:0] loadSeq;
  logic [MAX_SLOT-1:0] shiftReg;
  int                  slotL;
  int                  fieldW;
  int                  validW;

  always_ff @(posedge clk) begin
    if (!rst_n)    holdReg <= '0;
    else if (wrEn) holdReg <= wrData;
  end

  // valid width and right-aligned valid data
  always_comb begin
    slotL  = slotBits(slotLen);
    fieldW = align16 ? NARROW_W : HOLD_W;
    validW = (slotL < fieldW) ? slotL : fieldW;
    if (align16) fieldVal = {{(HOLD_W-NARROW_W){1'b0}}, holdReg[NARROW_W-1:0]};
    else         fieldVal = holdReg;
    rightData = fieldVal >> (fieldW - validW);
    wideData  = MAX_SLOT'(rightData);
    msbSeq    = wideData << (MAX_SLOT - validW);
  end

  // bit reversal: data LSB lands in the first-sent position
  for (genvar i = 0; i < MAX_SLOT; i++) begin : g_rev
    assign lsbSeq[MAX_SLOT-1-i] = wideData[i];
  end

  always_comb begin
    if (strb.fillZero) loadSeq = '0;
    else if (lsbFirst) loadSeq = lsbSeq;
    else               loadSeq = msbSeq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shiftReg <= '0;
      serOut   <= 1'b0;
    end else if (strb.loadSlot) begin
      serOut   <= loadSeq[MAX_SLOT-1];
      shiftReg <= loadSeq << 1;
    end else if (strb.shiftBit) begin
      serOut   <= shiftReg[MAX_SLOT-1];
      shiftReg <= shiftReg << 1;
    end else if (strb.quietBit) begin
      serOut   <= 1'b0;
    end
  end

endmodule

// File: rtl/slot_tx.sv
module slot_tx
  import slot_tx_pkg::*;
#(
  parameter int HOLD_W   = 24,
  parameter int NARROW_W = 16,
  parameter int MAX_SLOT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bitClkEn,
  input  logic              frameSync,
  input  logic              wrEn,
  input  logic [HOLD_W-1:0] wrData,
  input  logic [2:0]        slotLen,
  input  logic              lsbFirst,
  input  logic              align16,
  input  logic              irqEn,
  output logic              serOut,
  output logic              txEmpty,
  output logic              irq,
  output logic              underrun
);

  txStrobes_t strb;

  slot_tx_ctl #(.MAX_SLOT(MAX_SLOT)) u_ctl (
    .clk(clk), .rst_n(rst_n), .bitClkEn(bitClkEn), .frameSync(frameSync),
    .wrEn(wrEn), .slotLen(slotLen), .strb(strb), .txEmpty(txEmpty),
    .underrun(underrun)
  );

  slot_tx_dp #(.HOLD_W(HOLD_W), .NARROW_W(NARROW_W), .MAX_SLOT(MAX_SLOT)) u_dp (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData), .strb(strb),
    .slotLen(slotLen), .lsbFirst(lsbFirst), .align16(align16), .serOut(serOut)
  );

  assign irq = txEmpty & irqEn;

endmodule

// File: rtl/slot_tx_chk.sv
module slot_tx_chk
  import slot_tx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bitClkEn,
  input logic       frameSync,
  input logic       wrEn,
  input logic       irqEn,
  input logic       serOut,
  input logic       txEmpty,
  input logic       irq,
  input logic       underrun,
  input txStrobes_t strb
);

  p_still_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bitClkEn |=> $stable(serOut));

  p_quiet_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bitClkEn && !frameSync |=> !serOut);

  p_write_fills_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> !txEmpty);

  p_load_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadSlot && !wrEn |=> txEmpty);

  p_underrun_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadSlot && txEmpty |=> underrun);

  p_zero_first_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadSlot && txEmpty |=> !serOut);

  p_irq_needs_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> txEmpty && irqEn);

endmodule

bind slot_tx slot_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bitClkEn(bitClkEn), .frameSync(frameSync),
  .wrEn(wrEn), .irqEn(irqEn), .serOut(serOut), .txEmpty(txEmpty),
  .irq(irq), .underrun(underrun), .strb(strb)
);

// File: tb/sim_slot_tx.sv
module sim_slot_tx;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic        rst_n = 1'b0;
  logic        bitClkEn = 1'b0, frameSync = 1'b0, wrEn = 1'b0;
  logic [23:0] wrData = '0;
  logic [2:0]  slotLen = '0;
  logic        lsbFirst = 1'b0, align16 = 1'b0, irqEn = 1'b0;
  logic        serOut, txEmpty, irq, underrun;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  slot_tx u0 (.*);

  // ---------------- reference model ----------------
  bit          mFull, mSer, mUnder;
  logic [23:0] mHold;
  int          mPos, mLen;
  bit          mSeq [0:31];

  function automatic int lenOf(input logic [2:0] c);
    case (c)
      3'd0: return 8;  3'd1: return 12; 3'd2: return 16;
      3'd3: return 20; 3'd4: return 24; default: return 32;
    endcase
  endfunction

  always @(posedge clk) begin
    bit loadNow;
    loadNow = 0;
    if (!rst_n) begin
      mFull = 0; mSer = 0; mUnder = 0; mPos = 0; mLen = 8; mHold = '0;
    end else begin
      if (bitClkEn) begin
        if (!frameSync) mSer = 0;
        else if (mPos == 0) begin
          int fw, w;
          logic [23:0] f;
          loadNow = 1;
          mLen = lenOf(slotLen);
          fw = align16 ? 16 : 24;
          w  = (mLen < fw) ? mLen : fw;
          f  = align16 ? {8'h00, mHold[15:0]} : mHold;
          f  = f >> (fw - w);
          for (int i = 0; i < 32; i++) begin
            if (mFull && i < w) mSeq[i] = lsbFirst ? f[i] : f[w-1-i];
            else                mSeq[i] = 0;
          end
          mUnder = !mFull;
          mSer = mSeq[0];
          mPos = 1;
        end else begin
          mSer = mSeq[mPos];
          mPos = (mPos == mLen - 1) ? 0 : mPos + 1;
        end
      end
      if (wrEn) begin mFull = 1; mHold = wrData; end
      else if (loadNow) mFull = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 R3 R4 R5 R6 R7 R8 R9 serOut", serOut, mSer);
      chk("R10 txEmpty", txEmpty, !mFull);
      chk("R11 underrun", underrun, mUnder);
      chk("R12 irq", irq, (!mFull) && irqEn);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input bit fs, output bit b);
    repeat ($urandom_range(0, 2)) @(negedge clk);
    bitClkEn = 1; frameSync = fs;
    @(negedge clk);
    bitClkEn = 0;
    b = serOut;
  endtask

  task automatic write(input logic [23:0] w);
    wrEn = 1; wrData = w;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic runSlot(input int len, output logic [31:0] bits);
    bit b;
    bits = '0;
    for (int i = 0; i < len; i++) begin
      tick(1, b);
      bits[31-i] = b;
    end
    frameSync = 0;
  endtask

  task automatic setCfg(input logic [2:0] c, input bit l, input bit a);
    slotLen = c; lsbFirst = l; align16 = a;
  endtask

  logic [31:0] got;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 serOut", serOut, 0);
    chk("R1 txEmpty", txEmpty, 1);
    chk("R1 underrun", underrun, 0);
    chk("R1 irq", irq, 0);

    // R12 interrupt follows empty
    irqEn = 1; @(negedge clk);
    chk("R12 irq when empty", irq, 1);

    // R5 R7: 8-bit MSB-first, wide field
    setCfg(0, 0, 0); write(24'hA5C3F0);
    chk("R12 irq after write", irq, 0);
    chk("R10 not empty after write", txEmpty, 0);
    runSlot(8, got);
    chk("R5 R7 8-bit msb", got[31:24], 8'hA5);
    chk("R10 empty after transfer", txEmpty, 1);

    // R6: 8-bit LSB-first
    setCfg(0, 1, 0); write(24'hC13456);
    runSlot(8, got);
    chk("R6 8-bit lsb", got[31:24], 8'h83);

    // R8: narrow field, top byte ignored
    setCfg(2, 0, 1); write(24'hFF1234);
    runSlot(16, got);
    chk("R8 16-bit narrow", got[31:16], 16'h1234);

    // R4 R7: 12-bit slot
    setCfg(1, 0, 0); write(24'h987654);
    runSlot(12, got);
    chk("R4 R7 12-bit slot", got[31:20], 12'h987);

    // R9: 32-bit slot pads zeros
    setCfg(5, 0, 0); write(24'hABCDEF);
    runSlot(32, got);
    chk("R9 32-bit pad", got, 32'hABCDEF00);

    // R4: code 6 is 32 bits, then next slot starts cleanly
    setCfg(6, 0, 0); write(24'h800001);
    runSlot(32, got);
    chk("R4 code6 length", got, 32'h80000100);
    setCfg(0, 0, 0); write(24'hFF0000);
    runSlot(8, got);
    chk("R4 next slot aligned", got[31:24], 8'hFF);

    // R11: underrun slot
    runSlot(8, got);
    chk("R11 zero slot", got[31:24], 8'h00);
    chk("R11 underrun set", underrun, 1);
    write(24'h550000);
    chk("R10 write clears empty", txEmpty, 0);
    runSlot(8, got);
    chk("R5 after underrun", got[31:24], 8'h55);
    chk("R11 underrun cleared", underrun, 0);

    // R3: frame sync drops mid-slot
    begin
      bit b;
      write(24'hF00000);
      got = '0;
      for (int i = 0; i < 3; i++) begin tick(1, b); got[31-i] = b; end
      tick(0, b);
      chk("R3 quiet tick low", b, 0);
      for (int i = 3; i < 8; i++) begin tick(1, b); got[31-i] = b; end
      frameSync = 0;
      chk("R3 slot resumed", got[31:24], 8'hF0);
    end

    // randomized slots checked by the model every cycle
    for (int it = 0; it < 300; it++) begin
      bit b;
      int L;
      setCfg(3'($urandom_range(0, 7)), 1'($urandom), 1'($urandom));
      irqEn = 1'($urandom);
      if ($urandom_range(0, 9) < 8) write(24'($urandom));
      L = lenOf(slotLen);
      for (int i = 0; i < L; i++) begin
        tick(1, b);
        if ($urandom_range(0, 15) == 0) write(24'($urandom));
        if ($urandom_range(0, 20) == 0) begin tick(0, b); frameSync = 1; end
      end
      frameSync = 0;
      repeat ($urandom_range(0, 3)) tick(0, b);
    end

    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog R4 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule